// File: doc/BRIEF.md
# Indexed Voice Register Write Port

This block is the write side of a register file that is reached indirectly. A host first loads a voice selector and a function selector through two small byte ports. It then writes through a data port, which takes either a full 16-bit word or a single byte placed on the low or the high lane. Function codes in the lower range address a bank of per-voice 16-bit words. The word index is formed from the voice and function selectors. Byte writes merge into the stored word, so the lane that is not written keeps its value.

A small set of higher function codes reaches global state instead of the bank: the active voice count, a 20-bit sample memory address split into a 16-bit part and a 4-bit part, a DMA start word, a DMA high byte, three control bytes and a reset/run register. Writing the reset/run register with its run bit clear performs a soft reset. The soft reset loads defaults, and voice writes stay blocked until software sets the run bit again. A combinational peek port exposes any bank word, so the stored state can be observed.

Top module: `vreg_wport`

## Requirements
- R1: A write on port 0 loads the voice selector from data bits 7:0, and a write on port 1 loads the function selector from data bits 7:0. Neither write changes any other state.
- R2: A data write (port 2 or 3) while the function selector holds 0x00 to 0x0D targets the bank word at index voice[4:0]*16 + function[3:0]. Voice selector bits 7:5 are ignored.
- R3: A voice-specific data write leaves the bank unchanged while bit 0 (run) of the reset/run register is 0.
- R4: With byte_mode=0 the whole target word is replaced. With byte_mode=1, port 2 replaces bits 7:0 from data[7:0] and port 3 replaces bits 15:8 from data[7:0]. In both byte cases the other byte is kept.
- R5: Function 0x0E loads the voice count from data[7:0]. Function 0x0F and function codes that are not decoded change no state.
- R6: Function 0x43 writes address bits 15:0 under the R4 lane rules and keeps bits 19:16. Function 0x44 loads bits 19:16 from data[3:0] and keeps bits 15:0.
- R7: Function 0x42 writes the DMA start word under the R4 lane rules and clears bits 7:4 of the DMA high byte. Function 0x50 loads the DMA high byte from data[7:0].
- R8: Functions 0x41, 0x45 and 0x49 load the DMA control, timer control and sample control bytes from data[7:0].
- R9: Function 0x4C stores data[7:0] in the reset/run register. If data bit 0 is 0, the write also sets the voice count to 0xCD, clears the three control bytes and stores data[7:0] with bits 2:1 cleared. The address, the DMA start word and the DMA high byte are kept.
- R10: After rst_n the reset/run register, the selectors, the address, the DMA words and the control bytes are 0, and the voice count is 0xCD.
- R11: A cycle with wr_en=0, or with port_sel 4 to 7, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| port_sel | input | 3 | 0 voice sel, 1 function sel, 2 data low, 3 data high |
| byte_mode | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write data |
| peek_voice | input | 5 | Bank peek voice index |
| peek_func | input | 4 | Bank peek function index |
| peek_word | output | 16 | Bank word at the peek index |
| voice_sel | output | 8 | Voice selector |
| func_sel | output | 8 | Function selector |
| run_reg | output | 8 | Reset/run register |
| num_voices | output | 8 | Active voice count |
| mem_addr | output | 20 | Sample memory address |
| dma_start | output | 16 | DMA start word |
| dma_high | output | 8 | DMA high byte |
| dma_ctrl | output | 8 | DMA control byte |
| timer_ctrl | output | 8 | Timer control byte |
| samp_ctrl | output | 8 | Sample control byte |

## Verification
The assertions check the global registers on every cycle. They cover the soft-reset defaults, the split updates of the 20-bit address, the nibble clear on a DMA start write, and the stability of all registers on writes to undecoded ports or to function 0x0F. Bank contents, the lane merge into stored words, selector aliasing and run-bit gating depend on the data history of a particular word. Only the bench's scenarios can show them, by reading words back through the peek port.

// File: rtl/vreg_wport.sv
module vreg_wport #(
  parameter int VOICE_BITS = 5,
  parameter int FUNC_BITS  = 4,
  parameter int DW         = 16,
  parameter int AW         = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            port_sel,
  input  logic                  byte_mode,
  input  logic [DW-1:0]         wr_data,
  input  logic [VOICE_BITS-1:0] peek_voice,
  input  logic [FUNC_BITS-1:0]  peek_func,
  output logic [DW-1:0]         peek_word,
  output logic [7:0]            voice_sel,
  output logic [7:0]            func_sel,
  output logic [7:0]            run_reg,
  output logic [7:0]            num_voices,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         dma_start,
  output logic [7:0]            dma_high,
  output logic [7:0]            dma_ctrl,
  output logic [7:0]            timer_ctrl,
  output logic [7:0]            samp_ctrl
);
  localparam int IW    = VOICE_BITS + FUNC_BITS;
  localparam int DEPTH = 1 << IW;
  localparam int HB    = DW / 2;
  localparam logic [7:0] VCOUNT_DEF = 8'hCD;

  logic [DW-1:0] bank [DEPTH];
  logic [IW-1:0] widx;
  logic [DW-1:0] bank_new, addr_new, dma_new;
  logic data_wr, voice_fn, soft_rst;

  assign data_wr  = wr_en && (port_sel == 3'd2 || port_sel == 3'd3);
  assign voice_fn = func_sel <= 8'h0D;
  assign soft_rst = data_wr && func_sel == 8'h4C && !wr_data[0];
  assign widx     = {voice_sel[VOICE_BITS-1:0], func_sel[FUNC_BITS-1:0]};
  assign peek_word = bank[{peek_voice, peek_func}];

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old);
    if (!byte_mode)          return wr_data;
    else if (port_sel[0])    return {wr_data[HB-1:0], old[HB-1:0]};
    else                     return {old[DW-1:HB], wr_data[HB-1:0]};
  endfunction

  assign bank_new = lane_merge(bank[widx]);
  assign addr_new = lane_merge(mem_addr[DW-1:0]);
  assign dma_new  = lane_merge(dma_start);

  always_ff @(posedge clk)
    if (data_wr && voice_fn && run_reg[0]) bank[widx] <= bank_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      voice_sel  <= '0;
      func_sel   <= '0;
      run_reg    <= '0;
      num_voices <= VCOUNT_DEF;
      mem_addr   <= '0;
      dma_start  <= '0;
      dma_high   <= '0;
      dma_ctrl   <= '0;
      timer_ctrl <= '0;
      samp_ctrl  <= '0;
    end else if (wr_en && port_sel == 3'd0) begin
      voice_sel <= wr_data[7:0];
    end else if (wr_en && port_sel == 3'd1) begin
      func_sel <= wr_data[7:0];
    end else if (data_wr) begin
      case (func_sel)
        8'h0E: num_voices <= wr_data[7:0];
        8'h41: dma_ctrl   <= wr_data[7:0];
        8'h42: begin
          dma_start     <= dma_new;
          dma_high[7:4] <= 4'h0;
        end
        8'h43: mem_addr[DW-1:0] <= addr_new;
        8'h44: mem_addr[AW-1:DW] <= wr_data[AW-DW-1:0];
        8'h45: timer_ctrl <= wr_data[7:0];
        8'h49: samp_ctrl  <= wr_data[7:0];
        8'h50: dma_high   <= wr_data[7:0];
        8'h4C: begin
          if (soft_rst) begin
            run_reg    <= wr_data[7:0] & 8'hF9;
            num_voices <= VCOUNT_DEF;
            dma_ctrl   <= '0;
            timer_ctrl <= '0;
            samp_ctrl  <= '0;
          end else begin
            run_reg <= wr_data[7:0];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vreg_wport_chk.sv
module vreg_wport_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  port_sel,
  input logic [15:0] wr_data,
  input logic [7:0]  voice_sel,
  input logic [7:0]  func_sel,
  input logic [7:0]  run_reg,
  input logic [7:0]  num_voices,
  input logic [19:0] mem_addr,
  input logic [15:0] dma_start,
  input logic [7:0]  dma_high,
  input logic [7:0]  dma_ctrl,
  input logic [7:0]  timer_ctrl,
  input logic [7:0]  samp_ctrl
);
  logic dwr;
  assign dwr = wr_en && (port_sel == 3'd2 || port_sel == 3'd3);

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && func_sel == 8'h4C && !wr_data[0] |=>
      num_voices == 8'hCD && dma_ctrl == 8'h00 && timer_ctrl == 8'h00 &&
      samp_ctrl == 8'h00 && run_reg[2:0] == 3'b000);

  assert_addr_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && func_sel == 8'h44 |=>
      mem_addr[15:0] == $past(mem_addr[15:0]) && mem_addr[19:16] == $past(wr_data[3:0]));

  assert_addr_lo_keeps_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && func_sel == 8'h43 |=> $stable(mem_addr[19:16]));

  assert_dma_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && func_sel == 8'h42 |=> dma_high[7:4] == 4'h0 && dma_high[3:0] == $past(dma_high[3:0]));

  assert_idle_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && port_sel[2] |=>
      $stable(voice_sel) && $stable(func_sel) && $stable(run_reg) && $stable(num_voices) &&
      $stable(mem_addr) && $stable(dma_start) && $stable(dma_high) &&
      $stable(dma_ctrl) && $stable(timer_ctrl) && $stable(samp_ctrl));

  assert_readonly_fn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && func_sel == 8'h0F |=>
      $stable(num_voices) && $stable(mem_addr) && $stable(run_reg) && $stable(dma_start));
endmodule

bind vreg_wport vreg_wport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
  .voice_sel(voice_sel), .func_sel(func_sel), .run_reg(run_reg), .num_voices(num_voices),
  .mem_addr(mem_addr), .dma_start(dma_start), .dma_high(dma_high), .dma_ctrl(dma_ctrl),
  .timer_ctrl(timer_ctrl), .samp_ctrl(samp_ctrl)
);

// File: tb/vreg_wport_tb.sv
module vreg_wport_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, byte_mode = 0;
  logic [2:0] port_sel = 0;
  logic [15:0] wr_data = 0;
  logic [4:0] peek_voice = 0;
  logic [3:0] peek_func = 0;
  logic [15:0] peek_word, dma_start;
  logic [7:0] voice_sel, func_sel, run_reg, num_voices, dma_high, dma_ctrl, timer_ctrl, samp_ctrl;
  logic [19:0] mem_addr;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vreg_wport u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] p, input logic bm, input logic [15:0] d);
    @(negedge clk);
    port_sel = p; byte_mode = bm; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic fwr(input logic [7:0] fn, input logic [15:0] d);
    wr(3'd1, 0, {8'h0, fn});
    wr(3'd2, 0, d);
  endtask

  task automatic peek(input string tag, input logic [4:0] v, input logic [3:0] f, input logic [15:0] exp);
    peek_voice = v; peek_func = f; #1;
    chk(tag, peek_word, exp);
  endtask

  task automatic t_reset_state;
    chk("R10 run", run_reg, 0); chk("R10 vcount", num_voices, 8'hCD);
    chk("R10 addr", mem_addr, 0); chk("R10 dma", dma_start, 0);
    chk("R10 ctrl", {dma_ctrl, timer_ctrl, samp_ctrl}, 0);
  endtask

  task automatic t_voice_words;
    fwr(8'h4C, 16'h0007);
    chk("R9 run store", run_reg, 8'h07);
    wr(3'd0, 0, 16'h0003);
    chk("R1 voice sel", voice_sel, 8'h03);
    wr(3'd1, 0, 16'h0002);
    chk("R1 func sel", func_sel, 8'h02);
    wr(3'd2, 0, 16'hA55A);
    peek("R2 word", 3, 2, 16'hA55A);
    wr(3'd0, 0, 16'h0023);
    wr(3'd1, 0, 16'h0003);
    wr(3'd3, 0, 16'h1111);
    peek("R2 alias", 3, 3, 16'h1111);
    peek("R2 neighbour", 3, 2, 16'hA55A);
    wr(3'd1, 0, 16'h000D);
    wr(3'd0, 0, 16'h001F);
    wr(3'd2, 0, 16'h0BAD);
    peek("R2 last fn", 31, 13, 16'h0BAD);
  endtask

  task automatic t_lanes;
    wr(3'd0, 0, 16'h0003); wr(3'd1, 0, 16'h0002);
    wr(3'd2, 1, 16'hFFC3);
    peek("R4 low lane", 3, 2, 16'hA5C3);
    wr(3'd3, 1, 16'hEE71);
    peek("R4 high lane", 3, 2, 16'h71C3);
  endtask

  task automatic t_count;
    fwr(8'h0E, 16'h001E);
    chk("R5 vcount", num_voices, 8'h1E);
    fwr(8'h0F, 16'h0055);
    chk("R5 readonly", num_voices, 8'h1E);
    fwr(8'h60, 16'h0099);
    chk("R5 undecoded", {num_voices, run_reg, dma_ctrl}, {8'h1E, 8'h07, 8'h00});
  endtask

  task automatic t_addr;
    fwr(8'h44, 16'h00AB);
    chk("R6 hi nibble", mem_addr, 20'hB0000);
    fwr(8'h43, 16'h1234);
    chk("R6 lo word", mem_addr, 20'hB1234);
    wr(3'd3, 1, 16'h0056);
    chk("R6 hi byte", mem_addr, 20'hB5634);
    wr(3'd1, 0, 16'h0044); wr(3'd2, 0, 16'h0003);
    chk("R6 hi keep lo", mem_addr, 20'h35634);
  endtask

  task automatic t_dma_ctrl;
    fwr(8'h50, 16'h00FF);
    chk("R7 high load", dma_high, 8'hFF);
    fwr(8'h42, 16'hBEEF);
    chk("R7 start", dma_start, 16'hBEEF);
    chk("R7 nibble clr", dma_high, 8'h0F);
    wr(3'd2, 1, 16'h0011);
    chk("R7 low byte", dma_start, 16'hBE11);
    fwr(8'h41, 16'h0021); fwr(8'h45, 16'h000C); fwr(8'h49, 16'h0033);
    chk("R8 ctrl", {dma_ctrl, timer_ctrl, samp_ctrl}, 24'h210C33);
  endtask

  task automatic t_idle;
    wr(3'd5, 0, 16'h00FF);
    chk("R11 port5", {func_sel, voice_sel, samp_ctrl}, {8'h49, 8'h03, 8'h33});
    @(negedge clk); port_sel = 3'd2; wr_data = 16'h0000; wr_en = 0;
    @(negedge clk);
    chk("R11 no strobe", samp_ctrl, 8'h33);
  endtask

  task automatic t_soft_reset;
    fwr(8'h0E, 16'h0010);
    fwr(8'h4C, 16'h00FE);
    chk("R9 run", run_reg, 8'hF8);
    chk("R9 vcount", num_voices, 8'hCD);
    chk("R9 ctrl", {dma_ctrl, timer_ctrl, samp_ctrl}, 0);
    chk("R9 addr kept", mem_addr, 20'h35634);
    chk("R9 dma kept", {dma_start, dma_high}, {16'hBE11, 8'h0F});
    wr(3'd0, 0, 16'h0003); wr(3'd1, 0, 16'h0002);
    wr(3'd2, 0, 16'hFFFF);
    peek("R3 gated", 3, 2, 16'h71C3);
    fwr(8'h4C, 16'h0001);
    wr(3'd1, 0, 16'h0002); wr(3'd2, 0, 16'h4242);
    peek("R3 reopened", 3, 2, 16'h4242);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_voice_words();
    t_lanes();
    t_count();
    t_addr();
    t_dma_ctrl();
    t_idle();
    t_soft_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule